// File: doc/BRIEF.md
# Triggered Fan Tachometer Period Counter

This block times one revolution interval of a fan tachometer signal. Several tach inputs arrive asynchronously. One measurement is in flight at a time. Software selects the channel by raising one bit of a trigger vector: it first writes all zeros, then the one-hot bit. The block then waits for a qualifying edge on that channel's synchronised tach signal. It counts prescaled reference-clock ticks until the next qualifying edge, then raises a sticky done flag and holds the count.

The edge qualifier is picked by a 2-bit mode field: falling edges, rising edges, or every transition, with one code reserved. The counting tick is the reference clock divided by 4 shifted left by twice the divider field. A type-enable input gates the whole function. A count of zero with done set means that no ticks elapsed. Software that sees done stay clear concludes that the fan is stopped. Conversion to speed is left to the consumer.

Top module: `tach_period_counter`

## Requirements
- R1: After reset the result word is all zeros.
- R2: A 0-to-1 change of trigger bit n, while the type enable is high, arms a measurement on channel n. A trigger bit held high does not re-arm. When several bits rise in the same cycle, the lowest index is selected.
- R3: An accepted trigger clears both the done flag and the count, so the result reads zero in the next cycle.
- R4: With edge mode 00 only falling tach edges qualify. After the first qualifying edge the count equals floor((D-1)/P), where D is the clock-cycle distance to the next qualifying edge and P is the prescale factor.
- R5: With edge mode 01 only rising tach edges qualify, and the count is formed the same way.
- R6: With edge mode 10 every transition qualifies, so the count covers half a tach period.
- R7: With edge mode 11 no edge qualifies, and done stays clear.
- R8: The prescale factor P equals 4 << (2 × clk_div), giving 4, 16, 64 or 256 for the default 2-bit divider field.
- R9: The count stops at its all-ones value (2^CNT_W − 1) and never decreases, except when an accepted trigger clears it.
- R10: Done sits in result bit 31 and the count in bits CNT_W-1:0, with all other bits zero. Once set, done and the count are held until the next accepted trigger.
- R11: While type_en is low, triggers are ignored and the result does not change. Dropping type_en during a measurement abandons it, so done stays clear.
- R12: If the second qualifying edge never arrives, done stays clear.
- R13: Edges on channels other than the selected one have no effect on the measurement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tach_in | input | NUM_CH | Asynchronous tach inputs, one per channel |
| trig | input | NUM_CH | Trigger vector; a rising bit starts a measurement on that channel |
| edge_mode | input | 2 | 00 falling, 01 rising, 10 both, 11 reserved |
| clk_div | input | DIV_W | Prescale exponent; tick = clk / (4 << 2·clk_div) |
| type_en | input | 1 | Function enable for the measurement profile |
| result | output | 32 | {done, zeros, count[CNT_W-1:0]} |

## Verification
Several properties are checked on every cycle: the zero padding of the result word, the clearing of the word after an accepted trigger, the holding of done and the count once set, the count never falling outside a trigger, the frozen result while disabled, and the absence of completion in reserved mode. What the count should be for a given edge spacing, edge mode and prescale value can only be shown by the bench. The same applies to lowest-index selection, immunity to other channels, saturation and the abandoned run. The bench checks these with directed waveforms and compares them against its own cycle model on every clock.

// File: rtl/tach_pkg.sv
package tach_pkg;

   typedef enum logic [1:0] {
      EM_FALL = 2'b00,
      EM_RISE = 2'b01,
      EM_BOTH = 2'b10,
      EM_RSVD = 2'b11
   } edge_mode_e;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'b00,
      ST_ARMED = 2'b01,
      ST_COUNT = 2'b10
   } meas_state_e;

   localparam int RESULT_W = 32;
   localparam int DONE_POS = 31;

   // Width of a prescale counter able to reach (4 << 2*(2^div_w - 1)) - 1
   function automatic int pre_width(input int div_w);
      return 2 + 2 * ((1 << div_w) - 1);
   endfunction

endpackage

// File: rtl/tach_sync.sv
module tach_sync #(
   parameter int NUM_CH = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] tach_in,
   output logic [NUM_CH-1:0] rise_o,
   output logic [NUM_CH-1:0] fall_o
);

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      logic meta_q, sync_q, hist_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            hist_q <= 1'b0;
         end else begin
            meta_q <= tach_in[c];
            sync_q <= meta_q;
            hist_q <= sync_q;
         end
      end
      assign rise_o[c] =  sync_q & ~hist_q;
      assign fall_o[c] = ~sync_q &  hist_q;
   end

endmodule

// File: rtl/tach_trig.sv
module tach_trig #(
   parameter int NUM_CH = 16,
   localparam int IDX_W = $clog2(NUM_CH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] trig,
   input  logic              enable,
   output logic              start_o,
   output logic [IDX_W-1:0]  ch_o
);

   logic [NUM_CH-1:0] trig_q;
   logic [NUM_CH-1:0] rose;

   always_ff @(posedge clk) begin
      if (!rst_n) trig_q <= '0;
      else        trig_q <= trig;
   end

   assign rose    = trig & ~trig_q;
   assign start_o = enable & (|rose);

   // Scan from the top so the lowest set index is the final winner
   always_comb begin
      ch_o = '0;
      for (int i = NUM_CH - 1; i >= 0; i--) begin
         if (rose[i]) ch_o = IDX_W'(i);
      end
   end

endmodule

// File: rtl/tach_prescale.sv
module tach_prescale #(
   parameter int DIV_W = 2,
   localparam int PRE_W = tach_pkg::pre_width(DIV_W)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic [DIV_W-1:0] div,
   output logic             tick_o
);

   logic [PRE_W-1:0] pre_q;
   logic [PRE_W:0]   span;
   logic [PRE_W-1:0] last;

   assign span   = (PRE_W + 1)'(4) << {div, 1'b0};
   assign last   = PRE_W'(span - 1'b1);
   assign tick_o = !clear && (pre_q == last);

   always_ff @(posedge clk) begin
      if (!rst_n || clear) pre_q <= '0;
      else if (tick_o)     pre_q <= '0;
      else                 pre_q <= pre_q + 1'b1;
   end

endmodule

// File: rtl/tach_period_counter.sv
module tach_period_counter
   import tach_pkg::*;
#(
   parameter int NUM_CH = 16,
   parameter int CNT_W  = 20,
   parameter int DIV_W  = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_CH-1:0]   tach_in,
   input  logic [NUM_CH-1:0]   trig,
   input  logic [1:0]          edge_mode,
   input  logic [DIV_W-1:0]    clk_div,
   input  logic                type_en,
   output logic [RESULT_W-1:0] result
);

   localparam int IDX_W = $clog2(NUM_CH);
   localparam int PAD_W = DONE_POS - CNT_W;
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   if (NUM_CH < 2 || NUM_CH > 32) begin : g_bad_ch
      $error("tach_period_counter: NUM_CH must lie in 2..32");
   end
   if (CNT_W < 1 || CNT_W > 30) begin : g_bad_cnt
      $error("tach_period_counter: CNT_W must lie in 1..30");
   end
   if (DIV_W < 1 || DIV_W > 3) begin : g_bad_div
      $error("tach_period_counter: DIV_W must lie in 1..3");
   end

   logic [NUM_CH-1:0] rise_v, fall_v;
   logic              start;
   logic [IDX_W-1:0]  start_ch;
   logic              tick;
   logic              qual;

   meas_state_e       state_q;
   logic [IDX_W-1:0]  sel_q;
   logic [CNT_W-1:0]  cnt_q;
   logic              done_q;

   tach_sync #(.NUM_CH(NUM_CH)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .tach_in(tach_in),
      .rise_o (rise_v),
      .fall_o (fall_v)
   );

   tach_trig #(.NUM_CH(NUM_CH)) u_trig (
      .clk    (clk),
      .rst_n  (rst_n),
      .trig   (trig),
      .enable (type_en),
      .start_o(start),
      .ch_o   (start_ch)
   );

   tach_prescale #(.DIV_W(DIV_W)) u_pre (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (state_q != ST_COUNT),
      .div   (clk_div),
      .tick_o(tick)
   );

   always_comb begin
      unique case (edge_mode_e'(edge_mode))
         EM_FALL: qual = fall_v[sel_q];
         EM_RISE: qual = rise_v[sel_q];
         EM_BOTH: qual = fall_v[sel_q] | rise_v[sel_q];
         default: qual = 1'b0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         sel_q   <= '0;
         cnt_q   <= '0;
         done_q  <= 1'b0;
      end else if (!type_en) begin
         state_q <= ST_IDLE;
      end else if (start) begin
         state_q <= ST_ARMED;
         sel_q   <= start_ch;
         cnt_q   <= '0;
         done_q  <= 1'b0;
      end else begin
         unique case (state_q)
            ST_ARMED: if (qual) state_q <= ST_COUNT;
            ST_COUNT: begin
               if (qual) begin
                  done_q  <= 1'b1;
                  state_q <= ST_IDLE;
               end else if (tick && cnt_q != CNT_MAX) begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            default: ;
         endcase
      end
   end

   assign result = {done_q, {PAD_W{1'b0}}, cnt_q};

endmodule

// File: rtl/tach_period_counter_chk.sv
module tach_period_counter_chk #(
   parameter int NUM_CH = 16,
   parameter int CNT_W  = 20
) (
   input logic              clk,
   input logic              rst_n,
   input logic [NUM_CH-1:0] trig,
   input logic [1:0]        edge_mode,
   input logic              type_en,
   input logic [31:0]       result
);

   logic [NUM_CH-1:0] trig_prev;
   logic              accepted;

   always_ff @(posedge clk) begin
      if (!rst_n) trig_prev <= '0;
      else        trig_prev <= trig;
   end

   assign accepted = type_en && |(trig & ~trig_prev);

   // R10
   pad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      result[30:CNT_W] == '0);

   // R3
   trig_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      accepted |=> result == 32'd0);

   // R10
   done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (result[31] && !accepted) |=> (result[31] && $stable(result[CNT_W-1:0])));

   // R9
   no_decrease_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !accepted |=> result[CNT_W-1:0] >= $past(result[CNT_W-1:0]));

   // R11
   disabled_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !type_en |=> $stable(result));

   // R7
   reserved_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_mode == 2'b11 && !result[31]) |=> !result[31]);

endmodule

bind tach_period_counter tach_period_counter_chk #(
   .NUM_CH(NUM_CH),
   .CNT_W (CNT_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .trig     (trig),
   .edge_mode(edge_mode),
   .type_en  (type_en),
   .result   (result)
);

// File: tb/tb_tach_period_counter.sv
`timescale 1ns/1ps
module tb_tach_period_counter;

   localparam int NCH  = 16;
   localparam int CW   = 8;   // narrow count so saturation is reachable quickly
   localparam int DW   = 2;
   localparam int CMAX = (1 << CW) - 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NCH-1:0] tach = '0;
   logic [NCH-1:0] trig = '0;
   logic [1:0]    mode = 2'b00;
   logic [DW-1:0] div = '0;
   logic          en = 1'b1;
   logic [31:0]   result;

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   always #5 clk = ~clk;

   tach_period_counter #(.NUM_CH(NCH), .CNT_W(CW), .DIV_W(DW)) dut (
      .clk(clk), .rst_n(rst_n), .tach_in(tach), .trig(trig),
      .edge_mode(mode), .clk_div(div), .type_en(en), .result(result)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   int m_s1[NCH], m_s2[NCH], m_s3[NCH];
   int m_tq[NCH];
   int m_st, m_sel, m_pre, m_cnt, m_done;

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int c = 0; c < NCH; c++) begin
            m_s1[c] = 0; m_s2[c] = 0; m_s3[c] = 0; m_tq[c] = 0;
         end
         m_st = 0; m_sel = 0; m_pre = 0; m_cnt = 0; m_done = 0;
      end else begin
         int p, first, old_st, q, r, f;
         p = 4 << (2 * div);
         r = (m_s2[m_sel] == 1 && m_s3[m_sel] == 0);
         f = (m_s2[m_sel] == 0 && m_s3[m_sel] == 1);
         q = (mode == 0) ? f : (mode == 1) ? r : (mode == 2) ? (r | f) : 0;
         first = -1;
         for (int c = NCH - 1; c >= 0; c--)
            if (trig[c] && m_tq[c] == 0) first = c;
         old_st = m_st;
         if (!en) m_st = 0;
         else if (first >= 0) begin
            m_st = 1; m_sel = first; m_cnt = 0; m_done = 0;
         end else if (m_st == 1) begin
            if (q) m_st = 2;
         end else if (m_st == 2) begin
            if (q) begin m_done = 1; m_st = 0; end
            else if (m_pre == p - 1 && m_cnt < CMAX) m_cnt++;
         end
         if (old_st == 2) m_pre = (m_pre == p - 1) ? 0 : m_pre + 1;
         else m_pre = 0;
         for (int c = 0; c < NCH; c++) begin
            m_tq[c] = trig[c];
            m_s3[c] = m_s2[c]; m_s2[c] = m_s1[c]; m_s1[c] = tach[c];
         end
      end
   end

   always @(negedge clk) begin
      if (rst_n && !finished) begin
         logic [31:0] e;
         e = {m_done[0], 23'd0, 8'(m_cnt)};
         check("R10 model", result, e);
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic fire(input int ch);
      trig = '0; cyc(1);
      trig[ch] = 1'b1; cyc(1);
   endtask

   // Two qualifying edges d cycles apart on channel ch
   task automatic meas(input int ch, input int md, input int dv, input int d);
      int pre;
      mode = 2'(md); div = DW'(dv);
      pre = (md == 0 || md == 3) ? 1 : 0;
      tach[ch] = pre[0]; cyc(5);
      fire(ch); cyc(3);
      tach[ch] = ~pre[0];
      if (md == 2) begin
         cyc(d); tach[ch] = pre[0];
      end else begin
         cyc(d / 2); tach[ch] = pre[0];
         cyc(d - d / 2); tach[ch] = ~pre[0];
      end
      cyc(6);
   endtask

   function automatic logic [31:0] expd(input int dv, input int d);
      int c;
      c = (d - 1) / (4 << (2 * dv));
      if (c > CMAX) c = CMAX;
      return {1'b1, 23'd0, 8'(c)};
   endfunction

   initial begin
      logic [31:0] saved;
      cyc(3);
      rst_n = 1'b1; cyc(1);
      check("R1 reset", result, 32'd0);

      meas(3, 0, 0, 41);   check("R4 falling div0", result, expd(0, 41));
      meas(0, 1, 1, 100);  check("R5 rising div1", result, expd(1, 100));
      meas(15, 2, 0, 30);  check("R6 both-edges half period", result, expd(0, 30));
      meas(5, 0, 2, 200);  check("R8 div2", result, expd(2, 200));
      meas(6, 1, 3, 600);  check("R8 div3", result, expd(3, 600));

      // R10: further edges after done leave the result untouched
      saved = result;
      tach[6] = 1'b0; cyc(20); tach[6] = 1'b1; cyc(20);
      check("R10 sticky", result, saved);

      // R3: re-trigger clears in the next cycle
      trig = '0; cyc(1); trig[6] = 1'b1; cyc(1);
      check("R3 clear on trigger", result, 32'd0);

      meas(2, 3, 0, 40);   check("R7 reserved mode", result, 32'd0);

      // R13: arm channel 2, edges only on channel 7
      mode = 2'b00; div = '0; tach[2] = 1'b0; tach[7] = 1'b1; cyc(5);
      fire(2); cyc(3);
      tach[7] = 1'b0; cyc(10); tach[7] = 1'b1; cyc(10); tach[7] = 1'b0; cyc(10);
      check("R13 other channel", result[31], 1'b0);

      // R12: one edge only
      tach[4] = 1'b1; cyc(5); fire(4); cyc(3);
      tach[4] = 1'b0; cyc(300);
      check("R12 no second edge", result[31], 1'b0);

      meas(8, 0, 0, 1100); check("R9 saturation", result, expd(0, 1100));

      // R2: bits 9 and 4 rise together -> channel 4 selected
      mode = 2'b00; div = '0; tach[4] = 1'b1; tach[9] = 1'b1; cyc(5);
      trig = '0; cyc(1); trig[9] = 1'b1; trig[4] = 1'b1; cyc(3);
      tach[9] = 1'b0; cyc(10); tach[9] = 1'b1; cyc(10); tach[9] = 1'b0; cyc(10);
      check("R2 lowest index, ch9 ignored", result[31], 1'b0);
      tach[4] = 1'b0; cyc(21); tach[4] = 1'b1; cyc(20); tach[4] = 1'b0; cyc(6);
      check("R2 lowest index wins", result, expd(0, 41));
      // R2: held trigger does not re-arm
      saved = result; cyc(20);
      check("R2 held trigger", result, saved);

      // R11: disabled triggers ignored
      en = 1'b0; tach[1] = 1'b1; cyc(3);
      fire(1); cyc(3); tach[1] = 1'b0; cyc(10); tach[1] = 1'b1; cyc(10); tach[1] = 1'b0; cyc(6);
      check("R11 disabled trigger ignored", result, saved);
      // R11: abandon mid-measurement
      en = 1'b1; tach[1] = 1'b1; cyc(5); fire(1); cyc(3);
      tach[1] = 1'b0; cyc(10); en = 1'b0; cyc(2);
      tach[1] = 1'b1; cyc(10); tach[1] = 1'b0; cyc(6); en = 1'b1; cyc(5);
      check("R11 abandoned run", result[31], 1'b0);

      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         checks++; errors++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule